// File: doc/BRIEF.md
# Command List Pointer and Status Register Block

This block is the software-facing register set that sits in front of a rasteriser's command-list fetch engine. Software uses it to program where a command buffer begins and ends. Once a buffer is handed over, the block tracks the pointer the fetch engine starts from. It also holds a small status word with three mode bits and three busy flags. Beside the status word it runs four cycle counters: one for each busy input and one free-running clock count.

Software can queue the start of the next buffer while the current one is still running. A start write is latched only when no queued start is waiting, and it always marks a start as queued. A later end write moves the queued start into the current pointer, clears the queued mark, and fires a one-cycle strobe that tells the fetch engine to process the list. Mode bits are changed through set/clear pairs in which the clear wins. Counters are zeroed through dedicated clear bits in the same status write.

Top module: `cmdlist_ctrl`

## Requirements
- R1: After reset, all eight register addresses read zero and `process_o` is low.
- R2: A write to address 0 (start) loads `wr_data & 0xFFFFF8` only when status bit 10 (start queued) is clear. Bit 10 is set after any start write.
- R3: A write to address 1 (end) loads `wr_data & 0xFFFFF8` into the end register. If bit 10 was set, address 2 (current) takes the start value and bit 10 clears; otherwise current is unchanged.
- R4: `process_o` is high for exactly the one cycle after each end write and is never high after a write to any other address.
- R5: A status write (address 3) updates mode bits using pairs of write bits. Write bits 0/1 clear/set status bit 0, write bits 2/3 clear/set status bit 1 (freeze), and write bits 4/5 clear/set status bit 2. When both bits of a pair are written, the clear wins; when neither is written, the mode bit holds.
- R6: While `busy_in[i]` is high, counter i (addresses 5, 6 and 7 for i = 0, 1, 2) increments once per cycle and saturates at all-ones. Status bit 4+i is set and stays set after the input falls.
- R7: Status write bits 6, 7 and 8 zero counter 0, 1 and 2 respectively and clear the matching busy flag. The clear wins over an increment in the same cycle, and other counters are unaffected.
- R8: The clock counter (address 4) increments every cycle while freeze (status bit 1) is clear, holds while freeze is set, saturates at all-ones, and is zeroed by status write bit 9.
- R9: Writes to address 2 and to addresses 4 to 7 change nothing. Status bits 3, 7, 8, 9 and those above 10 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| busy_in | input | 3 | Busy inputs: 0 texture memory, 1 pipeline, 2 command |
| status_o | output | 11 | Live status word |
| process_o | output | 1 | One-cycle strobe after an end write |

## Verification
The properties take for granted that the register port carries at most one write per cycle and that `wr_addr` is a defined value whenever `wr_en` is high. The stimulus respects this by issuing every write through a single task that holds one address and data for exactly one clock edge. The properties also assume the busy inputs change only between edges. The stimulus keeps to this by changing `busy_in` only at falling edges, and it drives the register port low during reset so that no past-cycle term sees a write before the first active edge.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_END    = 3'd1,
        SEL_CUR    = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_CLOCK  = 3'd4,
        SEL_TMEM   = 3'd5,
        SEL_PIPE   = 3'd6,
        SEL_CMD    = 3'd7
    } reg_sel_e;

    localparam int STATUS_W    = 11;
    localparam int NMODE       = 3;
    localparam int NBUSY       = 3;
    // status read positions
    localparam int ST_MODE_LSB = 0;   // xbus, freeze, flush
    localparam int ST_FREEZE   = 1;
    localparam int ST_BUSY_LSB = 4;   // tmem, pipe, cmd
    localparam int ST_QUEUED   = 10;
    // status write positions
    localparam int WR_CTR_LSB  = 6;   // counter clears tmem, pipe, cmd
    localparam int WR_CLK_CLR  = 9;

endpackage

// File: rtl/cmdlist_sat_ctr.sv
module cmdlist_sat_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/cmdlist_mode_pairs.sv
module cmdlist_mode_pairs #(
    parameter int N = 3
) (
    input  logic         en,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_pair
        always_comb begin
            nxt[i] = cur[i];
            if (en) begin
                if (clr[i]) begin
                    nxt[i] = 1'b0;
                end else if (set[i]) begin
                    nxt[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmdlist_ctrl.sv
module cmdlist_ctrl
    import cmdlist_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 24,
    parameter int ALIGN_BITS = 3,
    parameter int CTR_W      = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [2:0]          rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NBUSY-1:0]    busy_in,
    output logic [STATUS_W-1:0] status_o,
    output logic                process_o
);
    localparam logic [DATA_W-1:0] ADDR_MASK =
        DATA_W'(((64'd1 << ADDR_W) - 64'd1) & ~((64'd1 << ALIGN_BITS) - 64'd1));

    typedef struct packed {
        logic [DATA_W-1:0] start_addr;
        logic [DATA_W-1:0] end_addr;
        logic [DATA_W-1:0] cur_addr;
        logic [NMODE-1:0]  mode;
        logic [NBUSY-1:0]  busy_flag;
        logic              queued;
        logic              process;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_start, wr_end, wr_status;
    logic [NMODE-1:0] mode_clr, mode_set, mode_nxt;
    logic [NBUSY-1:0] busy_clr;
    logic             clock_clr;
    logic [NBUSY-1:0][CTR_W-1:0] busy_cnt;
    logic [CTR_W-1:0] clock_cnt;
    logic [STATUS_W-1:0] status_word;

    // write decode
    always_comb begin
        wr_start  = wr_en && (reg_sel_e'(wr_addr) == SEL_START);
        wr_end    = wr_en && (reg_sel_e'(wr_addr) == SEL_END);
        wr_status = wr_en && (reg_sel_e'(wr_addr) == SEL_STATUS);
        for (int i = 0; i < NMODE; i++) begin
            mode_clr[i] = wr_data[2*i];
            mode_set[i] = wr_data[2*i+1];
        end
        busy_clr  = wr_status ? wr_data[WR_CTR_LSB +: NBUSY] : '0;
        clock_clr = wr_status && wr_data[WR_CLK_CLR];
    end

    cmdlist_mode_pairs #(.N(NMODE)) u_modes (
        .en  (wr_status),
        .cur (r_q.mode),
        .clr (mode_clr),
        .set (mode_set),
        .nxt (mode_nxt)
    );

    // next-state
    always_comb begin
        r_d         = r_q;
        r_d.process = wr_end;
        r_d.mode    = mode_nxt;
        if (wr_start) begin
            if (!r_q.queued) begin
                r_d.start_addr = wr_data & ADDR_MASK;
            end
            r_d.queued = 1'b1;
        end
        if (wr_end) begin
            r_d.end_addr = wr_data & ADDR_MASK;
            if (r_q.queued) begin
                r_d.cur_addr = r_q.start_addr;
                r_d.queued   = 1'b0;
            end
        end
        for (int i = 0; i < NBUSY; i++) begin
            if (busy_clr[i]) begin
                r_d.busy_flag[i] = 1'b0;
            end else if (busy_in[i]) begin
                r_d.busy_flag[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // counters
    for (genvar i = 0; i < NBUSY; i++) begin : g_busy
        cmdlist_sat_ctr #(.W(CTR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (busy_in[i]),
            .clr   (busy_clr[i]),
            .count (busy_cnt[i])
        );
    end

    cmdlist_sat_ctr #(.W(CTR_W)) u_clock (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (!r_q.mode[ST_FREEZE]),
        .clr   (clock_clr),
        .count (clock_cnt)
    );

    // status and read path
    always_comb begin
        status_word = '0;
        status_word[ST_MODE_LSB +: NMODE] = r_q.mode;
        status_word[ST_BUSY_LSB +: NBUSY] = r_q.busy_flag;
        status_word[ST_QUEUED]            = r_q.queued;
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_START:  rd_data = r_q.start_addr;
            SEL_END:    rd_data = r_q.end_addr;
            SEL_CUR:    rd_data = r_q.cur_addr;
            SEL_STATUS: rd_data = DATA_W'(status_word);
            SEL_CLOCK:  rd_data = DATA_W'(clock_cnt);
            SEL_TMEM:   rd_data = DATA_W'(busy_cnt[0]);
            SEL_PIPE:   rd_data = DATA_W'(busy_cnt[1]);
            SEL_CMD:    rd_data = DATA_W'(busy_cnt[2]);
            default:    rd_data = '0;
        endcase
    end

    assign status_o  = status_word;
    assign process_o = r_q.process;
endmodule

// File: rtl/cmdlist_ctrl_chk.sv
module cmdlist_ctrl_chk
    import cmdlist_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTR_W  = 24
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [2:0]                  wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [STATUS_W-1:0]         status_o,
    input logic                        process_o,
    input logic [DATA_W-1:0]           start_q,
    input logic [DATA_W-1:0]           cur_q,
    input logic [NBUSY-1:0][CTR_W-1:0] busy_cnt
);
    localparam logic [CTR_W-1:0] CMAX = '1;

    a_r4_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> process_o);

    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        process_o |-> $past(wr_en && wr_addr == 3'd1));

    a_r2_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && status_o[ST_QUEUED]) |=> $stable(start_q));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1 && status_o[ST_QUEUED])
        |=> (cur_q == $past(start_q) && !status_o[ST_QUEUED]));

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd3 && wr_data[2] && wr_data[3]) |=> !status_o[ST_FREEZE]);

    for (genvar i = 0; i < NBUSY; i++) begin : g_sat
        a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_cnt[i] == CMAX && !(wr_en && wr_addr == 3'd3 && wr_data[WR_CTR_LSB+i]))
            |=> busy_cnt[i] == CMAX);

        a_r7_clear_counter: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 3'd3 && wr_data[WR_CTR_LSB+i])
            |=> (busy_cnt[i] == '0 && !status_o[ST_BUSY_LSB+i]));
    end
endmodule

bind cmdlist_ctrl cmdlist_ctrl_chk #(.DATA_W(DATA_W), .CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .status_o  (status_o),
    .process_o (process_o),
    .start_q   (r_q.start_addr),
    .cur_q     (r_q.cur_addr),
    .busy_cnt  (busy_cnt)
);

// File: tb/sim_cmdlist_ctrl.sv
`timescale 1ns/10ps
module sim_cmdlist_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic [2:0]  busy_in;
    logic [10:0] status_o;
    logic        process_o;

    always #2 clk = ~clk;

    cmdlist_ctrl #(.CTR_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_in(busy_in),
        .status_o(status_o), .process_o(process_o)
    );

    localparam logic [31:0] CMAX = 32'd63;
    localparam logic [31:0] AMASK = 32'h00FF_FFF8;

    int n_run  = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic p);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        p     = process_o;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_tests();
        logic [31:0] v;
        logic [31:0] s;
        logic        p;
        logic [2:0]  exp_mode;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 reset strobe", {31'h0, process_o}, 32'h0);
        idle(1);

        // R2 start latch and queue
        wr(3'd0, 32'hFFFF_FFFF, p);
        check("R4 no strobe on start", {31'h0, p}, 32'h0);
        rd(3'd0, v); check("R2 start masked", v, 32'hFFFF_FFFF & AMASK);
        rd(3'd3, v); check("R2 queued set", {31'h0, v[10]}, 32'h1);
        wr(3'd0, 32'h0000_0123, p);
        rd(3'd0, v); check("R2 start held while queued", v, 32'h00FF_FFF8);

        // R3 end commit
        wr(3'd1, 32'h12AB_CDEF, p);
        check("R4 strobe after end", {31'h0, p}, 32'h1);
        rd(3'd1, v); check("R3 end masked", v, 32'h00AB_CDE8);
        rd(3'd2, v); check("R3 current from start", v, 32'h00FF_FFF8);
        rd(3'd3, v); check("R3 queued cleared", {31'h0, v[10]}, 32'h0);
        idle(1);
        check("R4 strobe one cycle", {31'h0, process_o}, 32'h0);
        wr(3'd1, 32'h0000_0040, p);
        check("R4 strobe on unqueued end", {31'h0, p}, 32'h1);
        rd(3'd2, v); check("R3 current kept without queue", v, 32'h00FF_FFF8);
        rd(3'd1, v); check("R3 end reload", v, 32'h0000_0040);
        wr(3'd0, 32'h0000_0777, p);
        rd(3'd0, v); check("R2 start relatch", v, 32'h0000_0770);
        wr(3'd1, 32'h0000_0800, p);
        rd(3'd2, v); check("R3 second commit", v, 32'h0000_0770);

        // R4 strobe only for end address
        for (int a = 0; a < 8; a++) begin
            wr(3'(a), 32'h0, p);
            check("R4 strobe per address", {31'h0, p}, (a == 1) ? 32'h1 : 32'h0);
        end

        // R9 current not writable (start 0 committed to current above)
        wr(3'd2, 32'h5555_5558, p);
        rd(3'd2, v); check("R9 current write ignored", v, 32'h0);

        // R5 exhaustive pair sweep
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 64; k++) begin
                int w;
                w = (rep == 0) ? k : ((k * 37) % 64);
                rd(3'd3, s);
                for (int i = 0; i < 3; i++) begin
                    if (w[2*i]) exp_mode[i] = 1'b0;
                    else if (w[2*i+1]) exp_mode[i] = 1'b1;
                    else exp_mode[i] = s[i];
                end
                wr(3'd3, 32'(w), p);
                rd(3'd3, v);
                check("R5 mode pairs", {29'h0, v[2:0]}, {29'h0, exp_mode});
            end
        end
        wr(3'd3, 32'h0000_0015, p);
        rd(3'd3, v);
        check("R9 reserved status bits", {28'h0, v[9], v[8], v[7], v[3]}, 32'h0);
        check("R5 all modes cleared", {29'h0, v[2:0]}, 32'h0);

        // R8 clock counter
        wr(3'd3, 32'h0000_0200, p);
        rd(3'd4, v); check("R8 clock cleared", v, 32'h0);
        idle(7);
        rd(3'd4, v); check("R8 clock counts", v, 32'd7);
        idle(100);
        rd(3'd4, v); check("R8 clock saturates", v, CMAX);
        wr(3'd3, 32'h0000_0008, p);
        wr(3'd3, 32'h0000_0200, p);
        idle(5);
        rd(3'd4, v); check("R8 clock frozen", v, 32'h0);
        wr(3'd3, 32'h0000_0204, p);
        rd(3'd4, v); check("R8 clear with unfreeze", v, 32'h0);
        idle(3);
        rd(3'd4, v); check("R8 clock resumes", v, 32'd3);

        // R6 busy counters
        wr(3'd3, 32'h0000_01C0, p);
        busy_in = 3'b001;
        idle(5);
        busy_in = 3'b000;
        rd(3'd5, v); check("R6 tmem count", v, 32'd5);
        rd(3'd3, v); check("R6 tmem flag", {29'h0, v[6:4]}, 32'h1);
        idle(4);
        rd(3'd5, v); check("R6 count holds when idle", v, 32'd5);
        rd(3'd3, v); check("R6 flag sticky", {29'h0, v[6:4]}, 32'h1);
        wr(3'd5, 32'h0000_0011, p);
        rd(3'd5, v); check("R9 counter write ignored", v, 32'd5);

        busy_in = 3'b010;
        idle(100);
        rd(3'd6, v); check("R6 pipe saturates", v, CMAX);
        wr(3'd3, 32'h0000_0080, p);
        rd(3'd6, v); check("R7 clear beats increment", v, 32'h0);
        rd(3'd3, v); check("R7 pipe flag cleared", {31'h0, v[5]}, 32'h0);
        idle(1);
        rd(3'd6, v); check("R6 pipe restarts", v, 32'd1);
        rd(3'd3, v); check("R6 pipe flag set again", {31'h0, v[5]}, 32'h1);
        busy_in = 3'b100;
        idle(3);
        busy_in = 3'b000;
        rd(3'd7, v); check("R6 cmd count", v, 32'd3);
        wr(3'd3, 32'h0000_0100, p);
        rd(3'd7, v); check("R7 cmd cleared", v, 32'h0);
        rd(3'd3, v); check("R7 cmd flag cleared", {31'h0, v[6]}, 32'h0);
        rd(3'd5, v); check("R7 other counter untouched", v, 32'd5);
        wr(3'd3, 32'h0000_0040, p);
        rd(3'd5, v); check("R7 tmem cleared", v, 32'h0);
        rd(3'd3, v); check("R7 tmem flag cleared", {31'h0, v[4]}, 32'h0);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = 3'd0;
        wr_data = 32'h0;
        rd_addr = 3'd0;
        busy_in = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin : main_seq
                run_tests();
            end
            begin : watchdog
                #(4 * 200000);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule